// File: doc/BRIEF.md
# SCSI Status and Interrupt Latch

This block is the event-capture front of a SCSI protocol controller's register file. The controller core, DMA engine and data FIFO all sit outside it. They report what happened as single-cycle pulses. Eight of these pulses are interrupt causes: bus reset seen, illegal command, disconnect or timeout, service request, function complete, reselected, selected with ATN, and selected without ATN. Four are status conditions: gross error, parity error, transfer count at zero, and valid group code. The block holds each pulse in a sticky bit until software acknowledges it.

Software reaches the block through a byte-wide read/write port with three addresses. Address 0 is the status byte. Its upper bits are latched and its three low bits show the live bus phase lines. Address 1 is the interrupt byte, and reading it acknowledges everything. Address 2 is a small configuration byte. The interrupt output is the pending flag gated by an enable input.

A read strobe at address 1 returns the current contents and clears them at the next clock edge. A pulse that arrives in that same cycle is not lost. A chip-reset pulse from the command decoder clears everything the same way, except that it drops same-cycle pulses.

Top module: `scsi_irq_status`

## Requirements
- R1: After the reset input is released, the status, interrupt and configuration bytes all read 0 with the phase lines low, and irq is 0.
- R2: A pulse on irq_evt[i] sets bit i of the interrupt byte (address 1) at the next clock edge, and the bit stays set until it is cleared. The bits from 7 down to 0 mean: bus reset detected, illegal command, disconnected or timeout, service requested, function complete, reselected, selected with ATN, selected without ATN.
- R3: A pulse on stat_evt[k] sets status bit 3+k at the next edge, and the bit stays set until the interrupt byte is read. Bit 6 is gross error, bit 5 is parity error, bit 4 is transfer count zero and bit 3 is valid group code. Several pulses accumulate by OR.
- R4: Status bits 2..0 are the live lines {phase_msg, phase_cd, phase_io}, with no latching. All eight codes pass through unchanged, including the illegal codes 4 and 5.
- R5: Status bit 7 is 1 exactly when the interrupt byte is nonzero, whatever the state of irq_en. The stat_evt pulses alone do not set it.
- R6: A cycle with cpu_rd=1 and cpu_addr=1 returns the interrupt byte on cpu_rdata in that cycle. At the following edge it clears the interrupt byte and status bits 7..3.
- R7: An irq_evt or stat_evt pulse in the same cycle as the clearing read of R6 is kept, and it is the only content present after the clear.
- R8: A soft_reset pulse clears the interrupt byte and status bits 7..3 at the next edge. It discards same-cycle event pulses and leaves the configuration byte unchanged.
- R9: irq equals status bit 7 AND irq_en.
- R10: Configuration bit 6 at address 2 is writable and readable, and the other bits there read 0. While bit 6 is 1, a bus-reset pulse (irq_evt[7]) with busrst_by_self=1 does not set interrupt bit 7. When bit 6 is 0, or when busrst_by_self is 0, the pulse sets bit 7 as usual.
- R11: Reading address 0, with any value of cpu_rd, changes nothing. Writes to address 0 or 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_evt | input | 8 | Interrupt-cause pulses, bit order as in R2 |
| stat_evt | input | 4 | Status-condition pulses: [3] gross, [2] parity, [1] count zero, [0] group code |
| busrst_by_self | input | 1 | Qualifies irq_evt[7] as caused by this controller's own reset-bus command |
| soft_reset | input | 1 | Chip-reset command pulse |
| phase_msg | input | 1 | Live MSG bus line |
| phase_cd | input | 1 | Live C/D bus line |
| phase_io | input | 1 | Live I/O bus line |
| cpu_addr | input | 2 | Register address |
| cpu_rd | input | 1 | Read strobe (side effect only at address 1) |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from cpu_addr |
| irq_en | input | 1 | Interrupt output enable |
| irq | output | 1 | Interrupt request |

## Verification
Event pulses and soft_reset take effect at the first clock edge after they are driven. A clearing read takes effect at the edge that ends its strobe cycle. The read data and irq are combinational, so they are valid within the cycle after that edge. The bench drives every input at a falling edge and samples one nanosecond later. Each result is therefore sampled a half cycle after the rising edge that should have produced it, and well before the next one. The phase lines are checked within the same half cycle in which they change. The captured value of a clearing read is sampled before the edge that clears it.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
   localparam int DATA_W       = 8;
   localparam int EVT_W        = 8;
   localparam int LAT_W        = 4;
   localparam int PHASE_W      = 3;
   localparam int ADR_STATUS   = 0;
   localparam int ADR_INTR     = 1;
   localparam int ADR_CFG      = 2;
   localparam int BUSRST_BIT   = 7;
   localparam int CFG_SUPP_BIT = 6;

   typedef struct packed {
      logic               pend;
      logic [LAT_W-1:0]   lat;
      logic [PHASE_W-1:0] phase;
   } stat_byte_t;
endpackage

// File: rtl/sirq_sticky_bank.sv
module sirq_sticky_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         rel,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sirq_sticky_bank: W must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (clr)
            q[i] <= 1'b0;
         else if (rel)
            q[i] <= set[i];
         else
            q[i] <= q[i] | set[i];
      end
   end
endmodule

// File: rtl/sirq_evt_filter.sv
module sirq_evt_filter #(
   parameter int W       = 8,
   parameter int GATE_BIT = 7
) (
   input  logic [W-1:0] evt_in,
   input  logic         by_self,
   input  logic         suppress,
   output logic [W-1:0] evt_out
);
   if (GATE_BIT >= W) begin : g_bad_bit
      $error("sirq_evt_filter: GATE_BIT out of range");
   end

   for (genvar i = 0; i < W; i++) begin : g_lane
      if (i == GATE_BIT) begin : g_gated
         assign evt_out[i] = evt_in[i] & ~(by_self & suppress);
      end else begin : g_pass
         assign evt_out[i] = evt_in[i];
      end
   end
endmodule

// File: rtl/sirq_read_mux.sv
module sirq_read_mux #(
   parameter int ADDR_W = 2,
   parameter int DW     = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     stat_b,
   input  logic [DW-1:0]     intr_b,
   input  logic [DW-1:0]     cfg_b,
   output logic [DW-1:0]     rdata
);
   import scsi_irq_pkg::*;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_STATUS))
         rdata = stat_b;
      else if (addr == ADDR_W'(ADR_INTR))
         rdata = intr_b;
      else if (addr == ADDR_W'(ADR_CFG))
         rdata = cfg_b;
   end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
   import scsi_irq_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        irq_evt,
   input  logic [3:0]        stat_evt,
   input  logic              busrst_by_self,
   input  logic              soft_reset,
   input  logic              phase_msg,
   input  logic              phase_cd,
   input  logic              phase_io,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   input  logic              irq_en,
   output logic              irq
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("scsi_irq_status: ADDR_W must be at least 2");
   end
   if (DATA_W != 1 + LAT_W + PHASE_W) begin : g_bad_layout
      $error("scsi_irq_status: status byte layout mismatch");
   end

   logic             rd_intr;
   logic             wr_cfg;
   logic             cfg_supp;
   logic [EVT_W-1:0] evt_f;
   logic [EVT_W-1:0] intr_q;
   logic [LAT_W-1:0] lat_q;
   logic             pending;
   stat_byte_t       stat_b;
   logic [DATA_W-1:0] cfg_b;

   assign rd_intr = cpu_rd && (cpu_addr == ADDR_W'(ADR_INTR));
   assign wr_cfg  = cpu_wr && (cpu_addr == ADDR_W'(ADR_CFG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_supp <= 1'b0;
      else if (wr_cfg)
         cfg_supp <= cpu_wdata[CFG_SUPP_BIT];
   end

   sirq_evt_filter #(.W(EVT_W), .GATE_BIT(BUSRST_BIT)) u_filt (
      .evt_in   (irq_evt),
      .by_self  (busrst_by_self),
      .suppress (cfg_supp),
      .evt_out  (evt_f)
   );

   sirq_sticky_bank #(.W(EVT_W)) u_intr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_reset),
      .rel   (rd_intr),
      .set   (evt_f),
      .q     (intr_q)
   );

   sirq_sticky_bank #(.W(LAT_W)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_reset),
      .rel   (rd_intr),
      .set   (stat_evt),
      .q     (lat_q)
   );

   assign pending = |intr_q;

   always_comb begin
      stat_b.pend  = pending;
      stat_b.lat   = lat_q;
      stat_b.phase = {phase_msg, phase_cd, phase_io};
      cfg_b        = '0;
      cfg_b[CFG_SUPP_BIT] = cfg_supp;
   end

   sirq_read_mux #(.ADDR_W(ADDR_W), .DW(DATA_W)) u_rmux (
      .addr   (cpu_addr),
      .stat_b (stat_b),
      .intr_b (intr_q),
      .cfg_b  (cfg_b),
      .rdata  (cpu_rdata)
   );

   assign irq = pending & irq_en;
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk #(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        irq_evt,
   input logic [3:0]        stat_evt,
   input logic              busrst_by_self,
   input logic              soft_reset,
   input logic              phase_msg,
   input logic              phase_cd,
   input logic              phase_io,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic [7:0]        cpu_rdata,
   input logic              irq_en,
   input logic              irq,
   input logic [7:0]        intr_q,
   input logic [3:0]        lat_q,
   input logic              cfg_supp
);
   logic rd_i;
   assign rd_i = cpu_rd && (cpu_addr == ADDR_W'(1));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && !soft_reset) |=> ((intr_q & $past(intr_q)) == $past(intr_q)));

   assert_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr == ADDR_W'(0)) |-> (cpu_rdata[2:0] == {phase_msg, phase_cd, phase_io}));

   assert_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr == ADDR_W'(0) && intr_q != 8'h00) |-> cpu_rdata[7]);

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !soft_reset && irq_evt == 8'h00 && stat_evt == 4'h0)
      |=> (intr_q == 8'h00 && lat_q == 4'h0));

   assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !soft_reset && irq_evt[6:0] != 7'h00)
      |=> (intr_q[6:0] == $past(irq_evt[6:0])));

   assert_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |=> (intr_q == 8'h00 && lat_q == 4'h0));

   assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   assert_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_evt[7] && busrst_by_self && cfg_supp && !intr_q[7]) |=> !intr_q[7]);

   assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && !soft_reset && irq_evt == 8'h00 && stat_evt == 4'h0)
      |=> ($stable(intr_q) && $stable(lat_q)));
endmodule

bind scsi_irq_status scsi_irq_status_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .irq_evt        (irq_evt),
   .stat_evt       (stat_evt),
   .busrst_by_self (busrst_by_self),
   .soft_reset     (soft_reset),
   .phase_msg      (phase_msg),
   .phase_cd       (phase_cd),
   .phase_io       (phase_io),
   .cpu_addr       (cpu_addr),
   .cpu_rd         (cpu_rd),
   .cpu_rdata      (cpu_rdata),
   .irq_en         (irq_en),
   .irq            (irq),
   .intr_q         (intr_q),
   .lat_q          (lat_q),
   .cfg_supp       (cfg_supp)
);

// File: tb/scsi_irq_status_bench.sv
`timescale 1ns/1ps
module scsi_irq_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_evt = '0;
   logic [3:0] stat_evt = '0;
   logic       busrst_by_self = 1'b0;
   logic       soft_reset = 1'b0;
   logic       phase_msg = 1'b0, phase_cd = 1'b0, phase_io = 1'b0;
   logic [1:0] cpu_addr = '0;
   logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       irq_en = 1'b0;
   logic       irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   scsi_irq_status u_scsi_irq_status (
      .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .stat_evt(stat_evt),
      .busrst_by_self(busrst_by_self), .soft_reset(soft_reset),
      .phase_msg(phase_msg), .phase_cd(phase_cd), .phase_io(phase_io),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .irq_en(irq_en), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      cpu_addr = a;
      cpu_rd   = 1'b0;
      #1;
      d = cpu_rdata;
   endtask

   task automatic pulse(input logic [7:0] ev, input logic [3:0] st, input logic self_f);
      @(negedge clk);
      irq_evt = ev; stat_evt = st; busrst_by_self = self_f;
      @(negedge clk);
      irq_evt = '0; stat_evt = '0; busrst_by_self = 1'b0;
   endtask

   task automatic rd_clear(input logic [7:0] ev, input logic [3:0] st, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = 2'd1; cpu_rd = 1'b1; irq_evt = ev; stat_evt = st;
      #1;
      d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0; irq_evt = '0; stat_evt = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk);
      cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = v;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(2'd0, d); chk("R1 status", d, 8'h00);
      peek(2'd1, d); chk("R1 intr", d, 8'h00);
      peek(2'd2, d); chk("R1 cfg", d, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      // R4 phase pass-through, all codes
      for (int p = 0; p < 8; p++) begin
         {phase_msg, phase_cd, phase_io} = 3'(p);
         peek(2'd0, d);
         chk("R4 phase", d, 8'(p));
      end
      {phase_msg, phase_cd, phase_io} = 3'd0;

      // R2 R5 R9 R6: each interrupt cause alone
      for (int b = 0; b < 8; b++) begin
         irq_en = b[0];
         pulse(8'(1 << b), 4'h0, 1'b0);
         peek(2'd1, d); chk("R2 bit set", d, 8'(1 << b));
         pulse(8'h00, 4'h0, 1'b0);
         peek(2'd1, d); chk("R2 bit held", d, 8'(1 << b));
         peek(2'd0, d); chk("R5 pending", d, 8'h80);
         chk("R9 irq", {7'd0, irq}, {7'd0, b[0]});
         rd_clear(8'h00, 4'h0, d); chk("R6 read value", d, 8'(1 << b));
         peek(2'd1, d); chk("R6 intr cleared", d, 8'h00);
         peek(2'd0, d); chk("R6 status cleared", d, 8'h00);
         chk("R9 irq low", {7'd0, irq}, 8'h00);
      end
      irq_en = 1'b1;

      // R3: every status-condition combination, with phase 3
      {phase_msg, phase_cd, phase_io} = 3'd3;
      for (int k = 0; k < 16; k++) begin
         pulse(8'h00, 4'(k), 1'b0);
         pulse(8'h00, 4'h0, 1'b0);
         peek(2'd0, d); chk("R3 latch", d, {1'b0, 4'(k), 3'd3});
         chk("R5 no pend from status", {7'd0, irq}, 8'h00);
         rd_clear(8'h00, 4'h0, d); chk("R6 intr empty", d, 8'h00);
         peek(2'd0, d); chk("R3 released", d, 8'h03);
      end
      {phase_msg, phase_cd, phase_io} = 3'd0;
      pulse(8'h00, 4'b0001, 1'b0);
      pulse(8'h00, 4'b0100, 1'b0);
      peek(2'd0, d); chk("R3 accumulate", d, 8'h28);
      rd_clear(8'h00, 4'h0, d);

      // R11: status read and stray writes change nothing
      pulse(8'h20, 4'b1000, 1'b0);
      @(negedge clk);
      cpu_addr = 2'd0; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hFF);
      peek(2'd1, d); chk("R11 intr kept", d, 8'h20);
      peek(2'd0, d); chk("R11 status kept", d, 8'hC0);

      // R7: event in the same cycle as the clearing read
      rd_clear(8'h02, 4'b0010, d); chk("R7 read value", d, 8'h20);
      peek(2'd1, d); chk("R7 kept intr", d, 8'h02);
      peek(2'd0, d); chk("R7 kept status", d, 8'h90);
      rd_clear(8'h00, 4'h0, d);

      // R10: configuration byte
      wr(2'd2, 8'hFF);
      peek(2'd2, d); chk("R10 cfg readback", d, 8'h40);
      pulse(8'h80, 4'h0, 1'b1);
      peek(2'd1, d); chk("R10 self reset suppressed", d, 8'h00);
      pulse(8'h80, 4'h0, 1'b0);
      peek(2'd1, d); chk("R10 external reset kept", d, 8'h80);
      rd_clear(8'h00, 4'h0, d);
      pulse(8'h81, 4'h0, 1'b1);
      peek(2'd1, d); chk("R10 only bit 7 gated", d, 8'h01);
      rd_clear(8'h00, 4'h0, d);

      // R8: soft reset drops same-cycle events, keeps config
      pulse(8'h0C, 4'b0101, 1'b0);
      @(negedge clk);
      soft_reset = 1'b1; irq_evt = 8'h10; stat_evt = 4'b0010;
      @(negedge clk);
      soft_reset = 1'b0; irq_evt = '0; stat_evt = '0;
      peek(2'd1, d); chk("R8 intr cleared", d, 8'h00);
      peek(2'd0, d); chk("R8 status cleared", d, 8'h00);
      peek(2'd2, d); chk("R8 cfg kept", d, 8'h40);

      wr(2'd2, 8'h00);
      peek(2'd2, d); chk("R10 cfg cleared", d, 8'h00);
      pulse(8'h80, 4'h0, 1'b1);
      peek(2'd1, d); chk("R10 self reset reported", d, 8'h80);
      s = d;
      peek(2'd0, d); chk("R5 pending bus reset", d, 8'h80);
      chk("R9 irq enabled", {7'd0, irq}, {7'd0, s[7]});

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule